// File: doc/BRIEF.md
# Character Display Host Register Interface

This block is the host side of a character display controller. A host reaches two 8-bit registers through a register-select line and a read/write line. The first is a command register that can only be written. The second is a data register that stands in front of two small memories: a 16x8 character-code RAM and a 32x5 glyph-pattern RAM. An address counter points into whichever memory the last address command chose. After every data read or write, the counter steps up or down and wraps inside that memory.

Data reads are pipelined. Whenever an address command lands, and again after every data read, the entry under the counter is fetched into the data register. A host read therefore returns a value that was fetched beforehand. Accepted commands and data writes start an internal busy interval. A status read returns the busy flag together with the counter.

Host accesses use a valid/ready handshake. An access is taken on a rising clock edge where `host_valid` and `host_ready` are both high. While `host_ready` is low, the host must hold `host_valid`, `host_rs`, `host_rw` and `host_wdata` steady. Status reads are never back-pressured. Every other access is held off while the block is busy, and for one cycle after each data read while the next entry is fetched. Read responses appear as a one-cycle `rsp_valid` pulse on the cycle after acceptance. They cannot be stalled, so the host must take them when they arrive.

Top module: `lcdif_host_regs`

## Requirements
- R1: After reset, `busy` is 0, `host_ready` is 1, the counter is 0 and points into the character-code RAM, a status read returns 0x00, and a data read returns 0x00.
- R2: A status read (rs=0, rw=1) responds one cycle after acceptance. Its data holds the busy flag in bit 7 and the zero-extended counter in bits 6..0.
- R3: The command 1xxxxxxx selects the character-code RAM and loads the counter from bits 3..0. The entry at that address is then fetched into the data register.
- R4: The command 01xxxxxx selects the glyph-pattern RAM and loads the counter from bits 4..0. The entry at that address is then fetched into the data register.
- R5: A data write (rs=1, rw=0) stores the byte at the counter's address in the selected RAM. A glyph-pattern write keeps only bits 4..0, and a later read of that entry returns them with bits 7..5 cleared.
- R6: A data read (rs=1, rw=1) returns the data register contents and steps the counter. It then fetches the entry at the new address, so back-to-back reads return consecutive entries.
- R7: The command 0000001d sets the step direction: d=1 increments and d=0 decrements. Increment is the direction after reset.
- R8: The counter wraps inside the selected RAM: 0x0F+1 gives 0x00 and 0x00-1 gives 0x0F in the character-code RAM, and 0x1F+1 gives 0x00 in the glyph-pattern RAM.
- R9: `busy` rises on the cycle after any accepted command or data write and stays high for exactly BUSY_CYCLES cycles. A data read does not raise it.
- R10: While `busy` is high, `host_ready` is low for command writes and all data accesses but stays high for status reads. `host_ready` is also low for non-status accesses on the cycle after a data read.
- R11: Command codes other than those in R3, R4 and R7 leave the counter, the selected RAM and the step direction unchanged, but still start a busy interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host access request |
| host_ready | output | 1 | Access can be taken this cycle |
| host_rs | input | 1 | Register select: 0 command/status, 1 data |
| host_rw | input | 1 | 1 read, 0 write |
| host_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | 8 | Read response byte |
| busy | output | 1 | Internal operation in progress |

## Verification
The handshake checks assume the host follows the stall rule: `host_rs` and `host_rw` stay fixed while a request is waiting, because `host_ready` depends on them. The bench drives every field on the falling edge and holds it until it sees an acceptance edge. The busy-window properties assume reset is held for at least one clock. The memory-depth parameters are assumed to be powers of two so that wrapping reduces to masking, and the bench uses only the default depths.

// File: rtl/lcdif_pkg.sv
package lcdif_pkg;

  typedef enum logic {
    TGT_CHAR = 1'b0,
    TGT_GLYPH = 1'b1
  } tgt_e;

  typedef enum logic [1:0] {
    CMD_OTHER,
    CMD_SET_CHAR,
    CMD_SET_GLYPH,
    CMD_DIR
  } cmd_e;

  typedef struct packed {
    cmd_e       kind;
    logic       dir_inc;
    logic [7:0] arg;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [7:0] code);
    cmd_t c;
    c.arg     = code;
    c.dir_inc = code[0];
    if (code[7])
      c.kind = CMD_SET_CHAR;
    else if (code[6])
      c.kind = CMD_SET_GLYPH;
    else if (code[7:1] == 7'b0000001)
      c.kind = CMD_DIR;
    else
      c.kind = CMD_OTHER;
    return c;
  endfunction

endpackage

// File: rtl/lcdif_busy_timer.sv
module lcdif_busy_timer #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (start)
      cnt <= CW'(CYCLES);
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_o);

  assert_busy_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !busy_o) |=> !busy_o);

endmodule

// File: rtl/lcdif_addr_ctr.sv
module lcdif_addr_ctr
  import lcdif_pkg::*;
#(
  parameter int CHAR_DEPTH  = 16,
  parameter int GLYPH_DEPTH = 32,
  localparam int CA_W = $clog2(CHAR_DEPTH),
  localparam int GA_W = $clog2(GLYPH_DEPTH),
  localparam int AW   = (CA_W > GA_W) ? CA_W : GA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  tgt_e          load_tgt,
  input  logic [AW-1:0] load_addr,
  input  logic          step,
  input  logic          dir_set,
  input  logic          dir_val,
  output logic [AW-1:0] ac,
  output tgt_e          tgt,
  output logic          dir_inc
);
  localparam logic [AW-1:0] CMASK = AW'(CHAR_DEPTH - 1);
  localparam logic [AW-1:0] GMASK = AW'(GLYPH_DEPTH - 1);

  logic [AW-1:0] cur_mask, new_mask, stepped;

  always_comb begin
    cur_mask = (tgt == TGT_GLYPH) ? GMASK : CMASK;
    new_mask = (load_tgt == TGT_GLYPH) ? GMASK : CMASK;
    stepped  = (dir_inc ? (ac + 1'b1) : (ac - 1'b1)) & cur_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac      <= '0;
      tgt     <= TGT_CHAR;
      dir_inc <= 1'b1;
    end else begin
      if (load) begin
        ac  <= load_addr & new_mask;
        tgt <= load_tgt;
      end else if (step) begin
        ac <= stepped;
      end
      if (dir_set)
        dir_inc <= dir_val;
    end
  end

  assert_ac_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt == TGT_CHAR) |-> (ac <= CMASK));

  assert_char_wrap_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && dir_inc && tgt == TGT_CHAR && ac == CMASK) |=> (ac == '0));

  assert_char_wrap_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !dir_inc && tgt == TGT_CHAR && ac == '0) |=> (ac == CMASK));

  assert_dir_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_set |=> $stable(dir_inc));

endmodule

// File: rtl/lcdif_store.sv
module lcdif_store
  import lcdif_pkg::*;
#(
  parameter int CHAR_DEPTH  = 16,
  parameter int CHAR_W      = 8,
  parameter int GLYPH_DEPTH = 32,
  parameter int GLYPH_W     = 5,
  parameter int DATA_W      = 8,
  localparam int CA_W = $clog2(CHAR_DEPTH),
  localparam int GA_W = $clog2(GLYPH_DEPTH),
  localparam int AW   = (CA_W > GA_W) ? CA_W : GA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  tgt_e              wtgt,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  tgt_e              rtgt,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [CHAR_W-1:0]  char_mem  [CHAR_DEPTH];
  logic [GLYPH_W-1:0] glyph_mem [GLYPH_DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CHAR_DEPTH; i++)
        char_mem[i] <= '0;
    end else if (we && wtgt == TGT_CHAR) begin
      char_mem[waddr[CA_W-1:0]] <= wdata[CHAR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < GLYPH_DEPTH; i++)
        glyph_mem[i] <= '0;
    end else if (we && wtgt == TGT_GLYPH) begin
      glyph_mem[waddr[GA_W-1:0]] <= wdata[GLYPH_W-1:0];
    end
  end

  always_comb begin
    if (rtgt == TGT_GLYPH)
      rdata = DATA_W'(glyph_mem[raddr[GA_W-1:0]]);
    else
      rdata = DATA_W'(char_mem[raddr[CA_W-1:0]]);
  end

  assert_glyph_narrow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rtgt == TGT_GLYPH) |-> (rdata[DATA_W-1:GLYPH_W] == '0));

endmodule

// File: rtl/lcdif_host_regs.sv
module lcdif_host_regs
  import lcdif_pkg::*;
#(
  parameter int CHAR_DEPTH  = 16,
  parameter int CHAR_W      = 8,
  parameter int GLYPH_DEPTH = 32,
  parameter int GLYPH_W     = 5,
  parameter int BUSY_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_valid,
  output logic       host_ready,
  input  logic       host_rs,
  input  logic       host_rw,
  input  logic [7:0] host_wdata,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  output logic       busy
);
  localparam int DATA_W = 8;
  localparam int STAT_W = DATA_W - 1;
  localparam int CA_W   = $clog2(CHAR_DEPTH);
  localparam int GA_W   = $clog2(GLYPH_DEPTH);
  localparam int AW     = (CA_W > GA_W) ? CA_W : GA_W;

  logic              is_status, accept;
  logic              cmd_wr, data_wr, data_rd, stat_rd;
  logic              fetch_pend;
  logic [DATA_W-1:0] data_reg, store_rdata;
  logic [AW-1:0]     ac;
  tgt_e              tgt;
  logic              dir_inc;
  cmd_t              cmd;
  logic              set_addr;
  tgt_e              set_tgt;

  assign is_status  = !host_rs && host_rw;
  assign host_ready = is_status || (!busy && !fetch_pend);
  assign accept     = host_valid && host_ready;
  assign cmd_wr     = accept && !host_rs && !host_rw;
  assign data_wr    = accept && host_rs && !host_rw;
  assign data_rd    = accept && host_rs && host_rw;
  assign stat_rd    = accept && is_status;

  always_comb begin
    cmd      = decode_cmd(host_wdata);
    set_addr = cmd_wr && (cmd.kind == CMD_SET_CHAR || cmd.kind == CMD_SET_GLYPH);
    set_tgt  = (cmd.kind == CMD_SET_GLYPH) ? TGT_GLYPH : TGT_CHAR;
  end

  lcdif_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (cmd_wr || data_wr),
    .busy_o (busy)
  );

  lcdif_addr_ctr #(.CHAR_DEPTH(CHAR_DEPTH), .GLYPH_DEPTH(GLYPH_DEPTH)) u_ac (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (set_addr),
    .load_tgt  (set_tgt),
    .load_addr (cmd.arg[AW-1:0]),
    .step      (data_wr || data_rd),
    .dir_set   (cmd_wr && cmd.kind == CMD_DIR),
    .dir_val   (cmd.dir_inc),
    .ac        (ac),
    .tgt       (tgt),
    .dir_inc   (dir_inc)
  );

  lcdif_store #(
    .CHAR_DEPTH (CHAR_DEPTH),
    .CHAR_W     (CHAR_W),
    .GLYPH_DEPTH(GLYPH_DEPTH),
    .GLYPH_W    (GLYPH_W),
    .DATA_W     (DATA_W)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (data_wr),
    .wtgt  (tgt),
    .waddr (ac),
    .wdata (host_wdata),
    .rtgt  (tgt),
    .raddr (ac),
    .rdata (store_rdata)
  );

  // Prefetch stage: one cycle after an address load or a data read,
  // the entry under the (already updated) counter lands in data_reg.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_pend <= 1'b0;
      data_reg   <= '0;
    end else begin
      fetch_pend <= set_addr || data_rd;
      if (fetch_pend)
        data_reg <= store_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= data_rd || stat_rd;
      if (stat_rd)
        rsp_data <= {busy, STAT_W'(ac)};
      else if (data_rd)
        rsp_data <= data_reg;
    end
  end

  assert_busy_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!host_ready || (!host_rs && host_rw)));

  assert_status_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_rs && host_rw) |-> host_ready);

  assert_fetch_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready && host_rs && host_rw) |=> (!host_ready || (!host_rs && host_rw)));

  assert_rsp_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready && host_rw) |=> rsp_valid);

  assert_rsp_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_valid && host_ready && host_rw) |=> !rsp_valid);

endmodule

// File: tb/lcdif_host_regs_tb.sv
module lcdif_host_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY_N     = 4;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_valid = 1'b0;
  logic       host_ready;
  logic       host_rs = 1'b0;
  logic       host_rw = 1'b0;
  logic [7:0] host_wdata = '0;
  logic       rsp_valid;
  logic [7:0] rsp_data;
  logic       busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lcdif_host_regs #(.BUSY_CYCLES(BUSY_N)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_valid (host_valid),
    .host_ready (host_ready),
    .host_rs    (host_rs),
    .host_rw    (host_rw),
    .host_wdata (host_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .busy       (busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Drive an access on the falling edge, wait for acceptance, return response.
  task automatic access(input logic rs, input logic rw, input logic [7:0] d,
                        output logic [7:0] r, output logic rv);
    host_rs = rs; host_rw = rw; host_wdata = d; host_valid = 1'b1;
    #1;
    while (!host_ready) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    r  = rsp_data;
    rv = rsp_valid;
  endtask

  task automatic wr_cmd(input logic [7:0] d);
    logic [7:0] r; logic rv;
    access(1'b0, 1'b0, d, r, rv);
  endtask

  task automatic wr_data(input logic [7:0] d);
    logic [7:0] r; logic rv;
    access(1'b1, 1'b0, d, r, rv);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic rd_status(input string req, input logic [7:0] exp);
    logic [7:0] r; logic rv;
    wait_idle();
    access(1'b0, 1'b1, 8'h00, r, rv);
    check(rv && r == exp, req, r, exp);
  endtask

  task automatic rd_data(input string req, input logic [7:0] exp);
    logic [7:0] r; logic rv;
    access(1'b1, 1'b1, 8'h00, r, rv);
    check(rv && r == exp, req, r, exp);
  endtask

  task automatic t_reset();
    host_rs = 1'b1; host_rw = 1'b0; #1;
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(host_ready == 1'b1, "R1 ready", host_ready, 1);
    rd_status("R1 status", 8'h00);
    rd_data("R1 data", 8'h00);
    rd_status("R1 counter stepped after read", 8'h01);
  endtask

  task automatic t_char_write_read();
    wr_cmd(8'h83);
    wr_data(8'h41); wr_data(8'h42); wr_data(8'h43);
    rd_status("R5 counter after writes", 8'h06);
    wr_cmd(8'h83);
    rd_data("R3 fetch on address set", 8'h41);
    rd_data("R6 next entry", 8'h42);
    rd_data("R6 third entry", 8'h43);
    rd_status("R6 counter after reads", 8'h06);
  endtask

  task automatic t_glyph();
    wr_cmd(8'h5E);
    rd_status("R4 glyph address load", 8'h1E);
    wr_data(8'hFF); wr_data(8'hAA);
    rd_status("R8 glyph wrap", 8'h00);
    wr_cmd(8'h5E);
    rd_data("R5 glyph low bits", 8'h1F);
    rd_data("R5 glyph narrow", 8'h0A);
  endtask

  task automatic t_char_wrap();
    wr_cmd(8'h8F);
    wr_data(8'h77);
    rd_status("R8 char wrap up", 8'h00);
    wr_cmd(8'h8F);
    rd_data("R8 read at last entry", 8'h77);
    rd_status("R8 wrap on read", 8'h00);
  endtask

  task automatic t_decrement();
    wr_cmd(8'h02);
    wr_cmd(8'h80);
    wr_data(8'h11);
    rd_status("R8 char wrap down", 8'h0F);
    wr_cmd(8'h85);
    rd_data("R7 dec read first", 8'h43);
    rd_data("R7 dec read second", 8'h42);
    rd_status("R7 dec counter", 8'h03);
    wr_cmd(8'h03);
    wr_cmd(8'h80);
    rd_data("R7 inc restored", 8'h11);
    rd_status("R7 inc counter", 8'h01);
  endtask

  task automatic t_busy();
    logic [7:0] r; logic rv;
    int n;
    wait_idle();
    wr_cmd(8'h84);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check(n == BUSY_N, "R9 busy length", n, BUSY_N);
    wr_cmd(8'h84);
    host_rs = 1'b1; host_rw = 1'b0; #1;
    check(host_ready == 1'b0, "R10 data blocked while busy", host_ready, 0);
    host_rs = 1'b0; host_rw = 1'b0; #1;
    check(host_ready == 1'b0, "R10 command blocked while busy", host_ready, 0);
    access(1'b0, 1'b1, 8'h00, r, rv);
    check(rv && r == 8'h84, "R10 status open while busy", r, 8'h84);
    wait_idle();
    access(1'b1, 1'b1, 8'h00, r, rv);
    check(r == 8'h42, "R6 read value", r, 8'h42);
    host_rs = 1'b1; host_rw = 1'b1; #1;
    check(host_ready == 1'b0, "R10 fetch gap", host_ready, 0);
    check(busy == 1'b0, "R9 read keeps busy low", busy, 0);
    @(negedge clk); #1;
    check(host_ready == 1'b1, "R10 ready after fetch", host_ready, 1);
  endtask

  task automatic t_other_cmd();
    wr_cmd(8'h87);
    wait_idle();
    wr_cmd(8'h01);
    check(busy == 1'b1, "R11 busy on other code", busy, 1);
    rd_status("R11 counter unchanged", 8'h07);
    wr_data(8'h55);
    rd_status("R11 direction unchanged", 8'h08);
    wr_cmd(8'h20);
    rd_status("R11 second code", 8'h08);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_char_write_read();
    t_glyph();
    t_char_wrap();
    t_decrement();
    t_busy();
    t_other_cmd();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=0x%0h expected=0x%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule